// File: doc/BRIEF.md
# Latched Input Status Register

This block watches a group of sixteen external digital input lines whose levels can change at any moment, with no relation to the system clock. Each line is brought into the clock domain through a short synchroniser chain. One 32-bit read returns two things side by side: the synchronised level of every line, and a sticky flag per line that records whether that line has been high at any time since its flag was last cleared.

Software polls the word to see both the present state of the inputs and any short pulses it would otherwise have missed between polls. It then clears the flags it has handled by writing ones to their positions. Flags that are written with zero are left alone, so several agents can each clear only the flags they own. The same block is instantiated once per input group, for example one copy for NIM-level inputs and one for LVDS-level inputs. All copies behave identically.

Top module: `io_latch_reg`

## Requirements
- R1: After reset every sticky flag is zero and the read data output `rdata_o` is zero.
- R2: A read strobe high at a rising clock edge loads `rdata_o` at that edge. `rdata_o` keeps this value until the next read strobe.
- R3: Bits 15..0 of the read word hold the synchronised live level of inputs 15..0 (bit n is input n). A level applied just before edge e is first returned by a read strobed at edge e+2.
- R4: Bits 31..16 of the read word hold the sticky flags (bit 16+n is the flag of input n). A flag sets one edge after its synchronised input is high, so a read strobed at edge e+3 is the first to see it. The flag stays set after the input drops.
- R5: A write strobe with bit n of `wdata_i` at 1 clears the flag of input n at that edge. Bits of `wdata_i[15:0]` at 0 leave their flags unchanged.
- R6: Bits 31..16 of `wdata_i` have no effect on any flag.
- R7: Writing 0x0000FFFF clears all sixteen flags in one access.
- R8: If a flag's set condition and its clear fall on the same edge, the flag ends set. No event is lost.
- R9: A read and a write strobed on the same edge return the flags as they were before that write's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 16 | Raw external input lines, asynchronous to clk |
| rd_stb_i | input | 1 | Decoded read strobe for this register |
| wr_stb_i | input | 1 | Decoded write strobe for this register |
| wdata_i | input | 32 | Write data; bits 15..0 are the clear mask |
| rdata_o | output | 32 | Registered read word: {sticky flags, live levels} |

## Verification
Two functions can meet on a single edge for the same bit: a flag being set by its synchronised input, and a write clearing that flag.

The bench provokes this in two ways. First, it holds an input high while writing all ones. Second, it sends a one-cycle pulse and strobes the clear exactly on the edge where the pulse reaches the flag stage. It then repeats the pulse with the clear one edge later, where the clear must win. Each outcome is judged by a later plain read of the flag.

A read coinciding with a clear is also exercised: that read must still show the pre-clear flags, and the read that follows must show them cleared.

// File: rtl/io_latch_pkg.sv
package io_latch_pkg;

    localparam int unsigned IOL_BUS_W       = 32;
    localparam int unsigned IOL_SYNC_STAGES = 2;

    typedef logic [IOL_BUS_W-1:0] bus_word_t;

endpackage

// File: rtl/io_latch_sync.sv
module io_latch_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.pipe[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            state_d.pipe[i] = state_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_o = state_q.pipe[STAGES-1];

endmodule

// File: rtl/io_latch_sticky.sv
module io_latch_sticky #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic             wr_stb_i,
    input  logic [WIDTH-1:0] clr_bits_i,
    output logic [WIDTH-1:0] sticky_o
);

    typedef struct packed {
        logic [WIDTH-1:0] flags;
    } sticky_state_t;

    sticky_state_t    state_d, state_q;
    logic [WIDTH-1:0] clr_mask;

    always_comb begin
        clr_mask = wr_stb_i ? clr_bits_i : '0;
        state_d  = state_q;
        // clear first, then OR in the set so a coinciding event survives
        state_d.flags = (state_q.flags & ~clr_mask) | level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sticky_o = state_q.flags;

    for (genvar g = 0; g < int'(WIDTH); g++) begin : g_chk
        assert_set_wins_R8 : assert property (@(posedge clk) disable iff (!rst_n)
            level_i[g] |=> sticky_o[g]);
        assert_flag_holds_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_o[g] && !(wr_stb_i && clr_bits_i[g])) |=> sticky_o[g]);
        assert_clear_takes_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb_i && clr_bits_i[g] && !level_i[g]) |=> !sticky_o[g]);
        assert_no_spurious_R4 : assert property (@(posedge clk) disable iff (!rst_n)
            (!sticky_o[g] && !level_i[g]) |=> !sticky_o[g]);
    end

endmodule

// File: rtl/io_latch_rdport.sv
module io_latch_rdport #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CH_W  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb_i,
    input  logic [CH_W-1:0]   live_i,
    input  logic [CH_W-1:0]   sticky_i,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } rd_state_t;

    rd_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rd_stb_i) begin
            state_d.word = {sticky_i, live_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o = state_q.word;

    assert_read_capture_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_i |=> (rdata_o == {$past(sticky_i), $past(live_i)}));
    assert_read_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> $stable(rdata_o));

endmodule

// File: rtl/io_latch_reg.sv
module io_latch_reg #(
    parameter int unsigned DATA_W      = io_latch_pkg::IOL_BUS_W,
    parameter int unsigned SYNC_STAGES = io_latch_pkg::IOL_SYNC_STAGES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_W/2-1:0]   pins_i,
    input  logic                  rd_stb_i,
    input  logic                  wr_stb_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o
);

    localparam int unsigned CH_W = DATA_W / 2;

    logic [CH_W-1:0] live_lvl;
    logic [CH_W-1:0] sticky_flags;
    logic            unused_wdata_hi;

    // upper half of the write word carries no meaning (R6)
    assign unused_wdata_hi = ^wdata_i[DATA_W-1:CH_W];

    io_latch_sync #(
        .WIDTH  (CH_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (live_lvl)
    );

    io_latch_sticky #(
        .WIDTH (CH_W)
    ) sticky_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (live_lvl),
        .wr_stb_i   (wr_stb_i),
        .clr_bits_i (wdata_i[CH_W-1:0]),
        .sticky_o   (sticky_flags)
    );

    io_latch_rdport #(
        .DATA_W (DATA_W)
    ) rdport_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb_i (rd_stb_i),
        .live_i   (live_lvl),
        .sticky_i (sticky_flags),
        .rdata_o  (rdata_o)
    );

    assert_reset_clear_R1 : assert property (@(posedge clk)
        !rst_n |=> (rdata_o == '0 && sticky_flags == '0) || !rst_n);

endmodule

// File: tb/io_latch_reg_tb_top.sv
`timescale 1ns/1ps
module io_latch_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    io_latch_reg dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_i   (pins),
        .rd_stb_i (rd_stb),
        .wr_stb_i (wr_stb),
        .wdata_i  (wdata),
        .rdata_o  (rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_word(output logic [31:0] v);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        v = rdata;
    endtask

    task automatic wr_word(input logic [31:0] w);
        wr_stb = 1'b1;
        wdata  = w;
        @(negedge clk);
        wr_stb = 1'b0;
        wdata  = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] acc;
        logic [15:0] p;
        tick(3);
        check("R1 rdata in reset", rdata, 32'h0);
        rst_n = 1'b1;
        tick(2);
        rd_word(v);
        check("R1 first read after reset", v, 32'h0);

        // R3/R4: exact latency of live and sticky bits
        pins = 16'h0004;
        rd_stb = 1'b1;
        @(negedge clk); check("R3 live not yet at e0", rdata, 32'h0);
        @(negedge clk); check("R3 live not yet at e1", rdata, 32'h0);
        @(negedge clk); check("R3 live at e2, flag not yet", rdata, 32'h0000_0004);
        @(negedge clk); check("R4 flag at e3", rdata, 32'h0004_0004);
        rd_stb = 1'b0;
        pins = 16'h0;
        tick(4);
        rd_word(v);
        check("R4 flag survives input drop", v, 32'h0004_0000);
        rd_word(v);
        tick(3);
        check("R2 rdata held without strobe", rdata, v);
        wr_word(32'h0000_FFFF);

        // walking single input: live shows bit, flags accumulate
        acc = '0;
        for (int b = 0; b < 16; b++) begin
            pins = 16'(1 << b);
            tick(4);
            acc |= 16'(1 << b);
            rd_word(v);
            check("R3 R4 walking high", v, {acc, 16'(1 << b)});
            pins = '0;
            tick(4);
            rd_word(v);
            check("R4 walking low", v, {acc, 16'h0});
        end

        // upper half of write ignored
        wr_word(32'hFFFF_0000);
        rd_word(v);
        check("R6 upper write half ignored", v, 32'hFFFF_0000);
        wr_word(32'h0000_5A5A);
        rd_word(v);
        check("R5 selective clear", v, 32'hA5A5_0000);
        acc = 16'hA5A5;
        for (int k = 0; k < 16; k++) begin
            wr_word(32'(1 << k) | 32'hC3C3_0000);
            acc &= ~16'(1 << k);
            rd_word(v);
            check("R5 single bit clear", v, {acc, 16'h0});
        end

        // pattern sweep with clear-all and coinciding read
        for (int i = 1; i < 33; i++) begin
            p = 16'((i * 32'h2B7D) ^ (i << 5));
            pins = p;
            tick(4);
            pins = '0;
            tick(4);
            rd_word(v);
            check("R4 pattern flags", v, {p, 16'h0});
            rd_stb = 1'b1;
            wr_word(32'h0000_FFFF);
            rd_stb = 1'b0;
            check("R9 read beside clear sees old flags", rdata, {p, 16'h0});
            rd_word(v);
            check("R7 clear all", v, 32'h0);
        end

        // set wins: input held high during clear-all
        pins = 16'h8001;
        tick(4);
        wr_word(32'h0000_FFFF);
        rd_word(v);
        check("R8 held input beats clear", v, 32'h8001_8001);
        pins = '0;
        tick(4);
        wr_word(32'h0000_FFFF);

        // set wins: pulse reaches flag stage on the clearing edge
        pins = 16'h0100;
        tick(1);
        pins = '0;
        tick(1);
        wr_word(32'h0000_0100);
        tick(3);
        rd_word(v);
        check("R8 coincident set and clear", v, 32'h0100_0000);
        wr_word(32'h0000_FFFF);

        // clear one edge after the set: clear wins
        pins = 16'h0100;
        tick(1);
        pins = '0;
        tick(2);
        wr_word(32'h0000_0100);
        tick(3);
        rd_word(v);
        check("R5 clear after set", v, 32'h0);

        // reset mid-run clears flags
        pins = 16'h00F0;
        tick(4);
        pins = '0;
        tick(4);
        rst_n = 1'b0;
        tick(2);
        check("R1 rdata after reset", rdata, 32'h0);
        rst_n = 1'b1;
        tick(4);
        rd_word(v);
        check("R1 flags cleared by reset", v, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule